// File: doc/BRIEF.md
# Asynchronous Peripheral Byte Loader

This block is the byte-wide configuration port that a host processor writes into. The host presents a byte on an 8-bit data bus together with a chip select and a write strobe. When the three-bit mode input carries the asynchronous-peripheral code and the port is idle, the byte is captured and the port raises a busy flag. Busy is the ready/busy handshake: the host may write the next byte only while busy reads low.

Each captured byte is shifted out most significant bit first on a serial data line. It is shifted by a burst of exactly eight clock pulses that the block makes itself from the system clock. No burst clock runs between bytes. The burst clock is driven out, so downstream slave devices can sample the serial data on its rising edges. Any write that arrives during a burst is dropped and sets a sticky overrun flag.

The oscillator is modelled by a system-clock divider. Each half period of the burst clock lasts `HALF_CLKS` system clocks.

Top module: `byte_burst_loader`

## Requirements
- R1: After reset, busy, burst_clk, ser_data and overrun are all 0.
- R2: A write counts as accepted when host_cs and host_wr are both 1 at a rising clock edge, mode_sel equals 3'b101 and busy is 0. busy reads 1 from the next cycle onward.
- R3: An accepted byte produces exactly eight burst_clk pulses. The first rise comes HALF_CLKS cycles after busy rises. Each pulse is high for HALF_CLKS cycles and low for HALF_CLKS cycles.
- R4: ser_data carries host_data bit 7 first and bit 0 last. Bit 7-k is on the line from 2*k*HALF_CLKS cycles after busy rises, for k = 0..7. ser_data changes only while burst_clk is 0.
- R5: busy returns to 0 HALF_CLKS cycles after the eighth falling edge of burst_clk. That is 17*HALF_CLKS cycles after it rose.
- R6: A write made while busy is 1 is ignored. The burst in progress keeps its original byte and its timing.
- R7: A write made while busy is 1 sets overrun. overrun stays 1 until reset.
- R8: A write with host_cs at 0, or with mode_sel other than 3'b101, is ignored. busy and burst_clk stay 0.
- R9: burst_clk is 0 whenever busy is 0.
- R10: A write made on the first cycle in which busy reads 0 is accepted and starts a new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the divider that makes the burst clock counts it |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Mode code; 3'b101 enables this port |
| host_cs | input | 1 | Chip select from the host, active high |
| host_wr | input | 1 | Write strobe from the host, active high |
| host_data | input | 8 | Byte written by the host |
| busy | output | 1 | Handshake: 1 while a byte is being shifted out |
| burst_clk | output | 1 | Burst clock for downstream slaves; eight pulses per byte |
| ser_data | output | 1 | Serial data, MSB first, stable at each rising edge of burst_clk |
| overrun | output | 1 | Sticky flag: a write arrived while busy |

## Verification
Two events can fall on the same cycle: a host write and an edge or final step of the burst in progress. The bench makes this happen by asserting the strobe in the middle of a burst. It then checks that every later cycle of busy, burst_clk and ser_data still matches the first byte, and that overrun rises one cycle after the colliding edge. The second case is a write presented on the very cycle busy falls. The bench judges it against a fresh cycle-exact waveform for the new byte, which starts with no gap.

// File: rtl/bbl_pkg.sv
package bbl_pkg;
  localparam logic [2:0] MODE_ASYNC_PERIPH = 3'b101;

  function automatic logic mode_enables(input logic [2:0] code);
    return code == MODE_ASYNC_PERIPH;
  endfunction

  function automatic logic strobe_hit(input logic cs, input logic wr, input logic [2:0] code);
    return cs && wr && mode_enables(code);
  endfunction
endpackage

// File: rtl/burst_timer.sv
module burst_timer #(
  parameter int HALF_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic half_done
);
  localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(HALF_CLKS - 1);

  logic [CW-1:0] cnt;

  assign half_done = run && !start && (cnt == LAST_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (start || half_done) cnt <= '0;
    else if (run)               cnt <= cnt + 1'b1;
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) < HALF_CLKS); // R3
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cnt == '0); // R3
endmodule

// File: rtl/byte_serializer.sv
module byte_serializer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              shift,
  output logic              ser_bit
);
  logic [DATA_W-1:0] shreg;

  assign ser_bit = shreg[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     shreg <= '0;
    else if (load)  shreg <= load_data;
    else if (shift) shreg <= {shreg[DATA_W-2:0], 1'b0};
  end

  AST_LOAD_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ser_bit == $past(load_data[DATA_W-1])); // R4
  AST_HOLD_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !shift |=> $stable(ser_bit)); // R4
endmodule

// File: rtl/byte_burst_loader.sv
module byte_burst_loader #(
  parameter int DATA_W    = 8,
  parameter int HALF_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_sel,
  input  logic              host_cs,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_data,
  output logic              busy,
  output logic              burst_clk,
  output logic              ser_data,
  output logic              overrun
);
  import bbl_pkg::*;

  localparam int HALVES = 2 * DATA_W + 1;
  localparam int HW     = $clog2(HALVES + 1);
  localparam logic [HW-1:0] LAST_HALF = HW'(HALVES - 1);
  localparam logic [HW-1:0] LAST_HIGH = HW'(HALVES - 2);

  logic [HW-1:0] half_idx;
  logic          wr_hit, accept, collide, half_done;
  logic          half_high, at_last;
  logic          rise_evt, fall_evt, end_evt, shift_evt;

  assign wr_hit    = strobe_hit(host_cs, host_wr, mode_sel);
  assign accept    = wr_hit && !busy;
  assign collide   = wr_hit && busy;
  assign half_high = half_idx[0];
  assign at_last   = (half_idx == LAST_HALF);
  assign rise_evt  = half_done && !half_high && !at_last;
  assign fall_evt  = half_done && half_high;
  assign end_evt   = half_done && at_last;
  assign shift_evt = fall_evt && (half_idx != LAST_HIGH);

  burst_timer #(.HALF_CLKS(HALF_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(accept), .run(busy), .half_done(half_done)
  );

  byte_serializer #(.DATA_W(DATA_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_data(host_data),
    .shift(shift_evt), .ser_bit(ser_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      half_idx  <= '0;
      burst_clk <= 1'b0;
    end else if (accept) begin
      busy      <= 1'b1;
      half_idx  <= '0;
      burst_clk <= 1'b0;
    end else if (end_evt) begin
      busy      <= 1'b0;
      half_idx  <= '0;
    end else if (half_done) begin
      half_idx  <= half_idx + 1'b1;
      burst_clk <= rise_evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       overrun <= 1'b0;
    else if (collide) overrun <= 1'b1;
  end

  AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy); // R2
  AST_END_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> !busy && !burst_clk); // R5
  AST_CLK_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !burst_clk); // R9
  AST_DATA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !$stable(ser_data) |-> !burst_clk); // R4
  AST_COLLIDE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    collide |=> overrun); // R7
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R7
  AST_COLLIDE_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    collide && !half_done |=> $stable(half_idx) && busy); // R6
  AST_IDLE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !wr_hit |=> !busy); // R8
endmodule

// File: tb/sim_byte_burst_loader.sv
module sim_byte_burst_loader;
  localparam int HALF = 4;
  localparam int BURST = 17 * HALF;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode_sel = 3'b000;
  logic       host_cs = 1'b0, host_wr = 1'b0;
  logic [7:0] host_data = 8'h00;
  logic       busy, burst_clk, ser_data, overrun;

  int checks = 0, fails = 0;
  logic ovr_model = 1'b0;

  always #10 clk = ~clk;

  byte_burst_loader #(.DATA_W(8), .HALF_CLKS(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .host_cs(host_cs),
    .host_wr(host_wr), .host_data(host_data), .busy(busy),
    .burst_clk(burst_clk), .ser_data(ser_data), .overrun(overrun)
  );

  // Row fields: [12] expect accept, [11:9] mode, [8] cs, [7:0] data
  localparam logic [12:0] VEC [7] = '{
    {1'b1, 3'b101, 1'b1, 8'hA5},
    {1'b0, 3'b000, 1'b1, 8'h77},
    {1'b1, 3'b101, 1'b1, 8'h3C},
    {1'b0, 3'b101, 1'b0, 8'hFF},
    {1'b1, 3'b101, 1'b1, 8'hFF},
    {1'b0, 3'b100, 1'b1, 8'h81},
    {1'b1, 3'b101, 1'b1, 8'h01}
  };

  task automatic run_byte(input logic [7:0] d, input logic [2:0] m, input logic cs,
                          input int coll, input logic acc, input int win, input string tag);
    int eb = 0, ec = 0, es = 0, eo = 0;
    mode_sel = m; host_cs = cs; host_data = d; host_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    for (int n = 0; n < win; n++) begin
      logic xb, xc, xs;
      int k;
      if (coll >= 0 && n == coll + 1) ovr_model = 1'b1;
      xb = acc && (n < BURST);
      xc = acc && (n < 16 * HALF) && ((n % (2 * HALF)) >= HALF);
      k = n / (2 * HALF);
      if (k > 7) k = 7;
      xs = d[7 - k];
      if (busy !== xb && eb == 0) begin
        eb = 1; $display("FAIL %s R2/R5/R8 busy n=%0d got %b exp %b", tag, n, busy, xb);
      end
      if (burst_clk !== xc && ec == 0) begin
        ec = 1; $display("FAIL %s R3/R9 burst_clk n=%0d got %b exp %b", tag, n, burst_clk, xc);
      end
      if (xb && ser_data !== xs && es == 0) begin
        es = 1; $display("FAIL %s R4 ser_data n=%0d got %b exp %b", tag, n, ser_data, xs);
      end
      if (overrun !== ovr_model && eo == 0) begin
        eo = 1; $display("FAIL %s R7 overrun n=%0d got %b exp %b", tag, n, overrun, ovr_model);
      end
      if (n == coll) begin
        host_cs = 1'b1; host_wr = 1'b1; host_data = ~d;
      end else begin
        host_cs = 1'b0; host_wr = 1'b0;
      end
      @(negedge clk);
    end
    checks += 4;
    fails  += eb + ec + es + eo;
  endtask

  task automatic check1(input logic got, input logic exp, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %b exp %b", what, got, exp);
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check1(busy, 1'b0, "R1 busy in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check1(busy, 1'b0, "R1 busy after reset");
    check1(burst_clk, 1'b0, "R1 burst_clk after reset");
    check1(ser_data, 1'b0, "R1 ser_data after reset");
    check1(overrun, 1'b0, "R1 overrun after reset");

    foreach (VEC[i])
      run_byte(VEC[i][7:0], VEC[i][11:9], VEC[i][8], -1, VEC[i][12], BURST + 3,
               VEC[i][12] ? "R2 table" : "R8 table");

    // R6 / R7: write in the middle of a burst
    run_byte(8'h5A, 3'b101, 1'b1, 20, 1'b1, BURST + 3, "R6 collide");
    // R6 / R7: write on the cycle of the final step while still busy
    run_byte(8'hC6, 3'b101, 1'b1, BURST - 1, 1'b1, BURST + 3, "R6 late collide");

    // R10: second write on the first cycle busy reads low
    run_byte(8'hC3, 3'b101, 1'b1, -1, 1'b1, BURST, "R10 first");
    check1(busy, 1'b0, "R10 busy low before second write");
    run_byte(8'h3C, 3'b101, 1'b1, -1, 1'b1, BURST + 3, "R10 second");

    // R7: overrun cleared only by reset
    check1(overrun, 1'b1, "R7 overrun still set");
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    ovr_model = 1'b0;
    @(negedge clk);
    check1(overrun, 1'b0, "R7 overrun cleared by reset");
    check1(burst_clk, 1'b0, "R9 burst_clk idle");

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule